// File: doc/BRIEF.md
# I2C Byte-Command Bus Master

This block is an I2C bus master that carries out one byte-level bus operation at a time under register control. Software places a byte in the transmit register and writes a command word. The word may ask for a START condition, a byte write, a byte read, a no-acknowledge on the read, and a STOP condition, and any of these may be combined in one write. The block runs the parts it was given in a fixed order: START, then the byte (write or read), then STOP. When the command finishes, the block sets a command-complete flag.

Each bus event sets its own sticky status flag, and software clears a flag by writing a one to it. A level interrupt is raised when the global interrupt enable is on and at least one flag is set whose own enable bit is also set. The SCL high and low phases take their lengths from two count registers. Acknowledge errors and lost arbitration are reported as flags. A bus-busy indication follows the START and STOP conditions seen on the synchronised pins. Both pins are open drain: an output enable pulls the line low, and the line level is read back through an input.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset the control and status registers read 0, the interrupt output is low and both line enables are released (0).
- R2: Every SCL low phase the master drives lasts exactly (low count + 1) clocks. Each SCL high phase lasts (high count + 1) clocks. SDA never changes its enable in the same clock as SCL changes its enable. The high count must be at least 2.
- R3: A command with start (bit 3) and write (bit 1) produces a START condition and then shifts out the transmit byte (offset 0x18) MSB first. It sets start-done (status bit 6), send-done (bit 4) and command-over (bit 0). Every command sets command-over when it ends.
- R4: If SDA is high in the acknowledge slot after a written byte, acknowledge-error (status bit 2) is set.
- R5: A read command (bit 2) clocks in one byte, stores it in the receive register (offset 0x1C), drives SDA low in the acknowledge slot and sets receive-done (status bit 3).
- R6: A read with no-ack (bit 4) in the same command leaves SDA released in the acknowledge slot.
- R7: A stop command (bit 0) produces a STOP condition and sets stop-done (status bit 5). Bus busy (status bit 7) sets on a detected START and clears on a detected STOP.
- R8: Writing ones to bits 6..0 of the clear register (offset 0x08) clears the matching status flags. Zero bits have no effect.
- R9: The interrupt is high only when control bit 7 is set and some status flag in bits 6..0 is set together with the matching control bit.
- R10: If SDA reads low at the end of the high phase of a data bit in which the master released it, the master sets arbitration-lost (bit 1) and command-over. It releases both lines and abandons the rest of the command.
- R11: A command written while another command is still running is ignored.
- R12: Start, write and stop given in one command run in that order on the bus.
- R13: While control bit 8 (enable) is 0, command writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word index of the register (byte offset bits 4..2) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA line level |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach is a lost arbitration, because it needs a second driver on SDA at the right moment. The bench's slave model has a separate force-low input. This input is raised on the SCL falling edge that opens the first bit of a byte that is all ones, so the master releases SDA but samples it low. A second difficult case is a command that arrives while the engine is busy. The bench writes a read command a few clocks after a write command has started, then confirms that only the written byte appears on the bus and that the bus stays quiet afterwards.

// File: rtl/i2c_cmd_master.sv
`timescale 1ns/1ps
module i2c_cmd_master #(
  parameter int CW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:2]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        scl_oe,
  input  logic        scl_in,
  output logic        sda_oe,
  input  logic        sda_in,
  output logic        irq
);

  localparam logic [2:0] A_CTRL = 3'd0, A_CMD = 3'd1, A_CLR = 3'd2, A_STAT = 3'd3,
                         A_HI = 3'd4, A_LO = 3'd5, A_TX = 3'd6, A_RX = 3'd7;

  typedef enum logic [3:0] {IDLE, S_LO, S_HI, S_SDA, B_LO, B_HI, P_LO, P_HI, P_REL} st_t;

  st_t st, tgt;
  logic          jump;
  logic [8:0]    ctrl;
  logic [CW-1:0] hcnt, lcnt, cnt;
  logic [7:0]    txb, rxb, sh;
  logic [6:0]    stat;
  logic          busy;
  logic          c_nack, c_rd, c_wr, c_stop;
  logic [3:0]    bitn;
  logic          scl_drv, sda_drv, sda_want;
  logic [1:0]    scl_sy, sda_sy;
  logic          sda_p;
  logic          unused_bits;

  wire wr_cmd = reg_we && reg_addr == A_CMD;
  wire wr_clr = reg_we && reg_addr == A_CLR;
  wire go     = wr_cmd && st == IDLE && ctrl[8] && |reg_wdata[3:0];
  wire [6:0] clr_mask = wr_clr ? reg_wdata[6:0] : 7'd0;
  wire nb_wr  = (st == IDLE) ? reg_wdata[1] : c_wr;
  wire arb    = c_wr && bitn < 4'd8 && sh[7] && !sda_sy[1];

  assign unused_bits = ^reg_wdata;
  assign scl_oe = scl_drv;
  assign sda_oe = sda_drv;
  assign irq    = ctrl[7] & |(stat & ctrl[6:0]);

  function automatic st_t route(input logic s, input logic w, input logic r, input logic p);
    if (s)          return S_LO;
    else if (w | r) return B_LO;
    else if (p)     return P_LO;
    else            return IDLE;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0; hcnt <= '0; lcnt <= '0; txb <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL: ctrl <= reg_wdata[8:0];
        A_HI:   hcnt <= reg_wdata[CW-1:0];
        A_LO:   lcnt <= reg_wdata[CW-1:0];
        A_TX:   txb  <= reg_wdata[7:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; sda_p <= 1'b1; busy <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      sda_p  <= sda_sy[1];
      if (scl_sy[1] && sda_p && !sda_sy[1])      busy <= 1'b1;
      else if (scl_sy[1] && !sda_p && sda_sy[1]) busy <= 1'b0;
    end

  always_comb begin
    jump = 1'b0;
    tgt  = st;
    case (st)
      IDLE:  if (go) begin jump = 1'b1; tgt = route(reg_wdata[3], reg_wdata[1], reg_wdata[2], reg_wdata[0]); end
      S_LO:  if (cnt == '0) begin jump = 1'b1; tgt = S_HI; end
      S_HI:  if (cnt == '0) begin jump = 1'b1; tgt = S_SDA; end
      S_SDA: if (cnt == '0) begin jump = 1'b1; tgt = route(1'b0, c_wr, c_rd, c_stop); end
      B_LO:  if (cnt == '0) begin jump = 1'b1; tgt = B_HI; end
      B_HI:  if (cnt == '0) begin
               jump = 1'b1;
               if (bitn < 4'd8) tgt = arb ? IDLE : B_LO;
               else             tgt = route(1'b0, 1'b0, 1'b0, c_stop);
             end
      P_LO:  if (cnt == '0) begin jump = 1'b1; tgt = P_HI; end
      P_HI:  if (cnt == '0) begin jump = 1'b1; tgt = P_REL; end
      P_REL: if (cnt == '0) begin jump = 1'b1; tgt = IDLE; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; stat <= '0; rxb <= '0; sh <= '0; bitn <= '0;
      scl_drv <= 1'b0; sda_drv <= 1'b0; sda_want <= 1'b0;
      c_nack <= 1'b0; c_rd <= 1'b0; c_wr <= 1'b0; c_stop <= 1'b0;
    end else begin
      stat <= stat & ~clr_mask;
      if (st inside {S_LO, B_LO, P_LO}) sda_drv <= sda_want;
      if (go) {c_nack, c_rd, c_wr, c_stop} <= {reg_wdata[4], reg_wdata[2:0]};
      if (st == S_SDA && jump) stat[6] <= 1'b1;
      if (st == P_REL && jump) stat[5] <= 1'b1;
      if (st == B_HI && jump && bitn == 4'd8) begin
        if (c_wr) begin
          stat[4] <= 1'b1;
          if (sda_sy[1]) stat[2] <= 1'b1;
        end else begin
          stat[3] <= 1'b1;
          rxb     <= sh;
        end
      end
      if (jump) begin
        st <= tgt;
        case (tgt)
          S_LO:  begin scl_drv <= 1'b1; cnt <= lcnt; sda_want <= 1'b0; end
          P_LO:  begin scl_drv <= 1'b1; cnt <= lcnt; sda_want <= 1'b1; end
          S_HI, B_HI, P_HI: begin scl_drv <= 1'b0; cnt <= hcnt; end
          S_SDA: begin sda_drv <= 1'b1; cnt <= hcnt; end
          P_REL: begin sda_drv <= 1'b0; cnt <= hcnt; end
          B_LO: begin
            scl_drv <= 1'b1;
            cnt     <= lcnt;
            if (st == B_HI) begin
              bitn     <= bitn + 4'd1;
              sh       <= {sh[6:0], sda_sy[1]};
              sda_want <= (bitn < 4'd7) ? (c_wr & ~sh[6]) : (~c_wr & ~c_nack);
            end else begin
              bitn     <= '0;
              sh       <= txb;
              sda_want <= nb_wr & ~txb[7];
            end
          end
          IDLE: begin
            stat[0] <= 1'b1;
            if (st == B_HI && arb) begin
              stat[1] <= 1'b1;
              scl_drv <= 1'b0;
              sda_drv <= 1'b0;
            end
          end
          default: ;
        endcase
      end else if (st != IDLE) begin
        cnt <= cnt - 1'b1;
      end
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata[8:0]    = ctrl;
      A_STAT: reg_rdata[7:0]    = {busy, stat};
      A_HI:   reg_rdata[CW-1:0] = hcnt;
      A_LO:   reg_rdata[CW-1:0] = lcnt;
      A_TX:   reg_rdata[7:0]    = txb;
      A_RX:   reg_rdata[7:0]    = rxb;
      default: ;
    endcase
  end

  p_edge_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe != $past(scl_oe)) |-> (sda_oe == $past(sda_oe)));

  p_over_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && $past(st) != IDLE) |-> stat[0]);

  p_clear_over_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && reg_wdata[0] && st == IDLE) |=> !stat[0]);

  p_arb_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[1]) |-> (!scl_oe && !sda_oe));

  p_cmd_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && st != IDLE) |=> $stable({c_nack, c_rd, c_wr, c_stop}));

  p_off_no_run_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !ctrl[8] && st == IDLE) |=> st == IDLE);

endmodule

// File: tb/test_i2c_cmd_master.sv
`timescale 1ns/1ps
module test_i2c_cmd_master;
  localparam int LO = 4, HI = 5;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [4:2] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic scl_oe, sda_oe, irq;
  logic slv_pull = 0, force_low = 0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe | slv_pull | force_low);

  int checks = 0, errors = 0;
  bit done = 0;

  i2c_cmd_master i_i2c_cmd_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe),
    .scl_in(scl_line), .sda_oe(sda_oe), .sda_in(sda_line), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model on the bus lines
  int bitcnt = 0, n_start = 0, n_stop = 0;
  logic [7:0] sh_s = 0, cur_tx = 0;
  logic [7:0] rxq[$], txq[$];
  bit addr_ph = 0, is_rd = 0, rd_data = 0, mack = 0, ack_en = 1;
  logic ps = 1, pd = 1;

  always @(scl_line or sda_line) begin
    if (scl_line !== ps) begin
      if (scl_line) begin
        if (bitcnt < 8) sh_s = {sh_s[6:0], sda_line};
        else if (bitcnt == 8 && rd_data) mack = sda_line;
        bitcnt++;
      end else begin
        if (bitcnt == 8) begin
          if (rd_data) slv_pull = 0;
          else begin
            rxq.push_back(sh_s);
            if (addr_ph) begin is_rd = sh_s[0]; addr_ph = 0; end
            slv_pull = ack_en;
          end
        end else if (bitcnt == 9) begin
          bitcnt = 0; slv_pull = 0; rd_data = 0;
          if (is_rd && !mack) begin
            cur_tx = (txq.size() > 0) ? txq.pop_front() : 8'hFF;
            rd_data = 1;
            slv_pull = ~cur_tx[7];
          end
        end else if (rd_data && bitcnt >= 1 && bitcnt < 8) begin
          slv_pull = ~cur_tx[7-bitcnt];
        end
      end
    end else if (sda_line !== pd && scl_line) begin
      if (!sda_line) begin n_start++; addr_ph = 1; mack = 0; end
      else n_stop++;
      bitcnt = 0; is_rd = 0; rd_data = 0; slv_pull = 0;
    end
    ps = scl_line; pd = sda_line;
  end

  // per-clock timing model of the SCL low phase and line ordering
  int lo_run = 0;
  logic pscl = 0, psda = 0;
  always @(negedge clk) if (rst_n) begin
    if (scl_oe) lo_run++;
    else if (lo_run > 0) begin
      chk("R2 scl low length", lo_run, LO + 1);
      lo_run = 0;
    end
    if (scl_oe !== pscl) chk("R2 sda steady on scl edge", sda_oe, psda);
    pscl = scl_oe; psda = sda_oe;
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a[4:2]; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a[4:2]; #1; d = reg_rdata;
  endtask

  task automatic wait_over(input string req);
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(5'h0C, s);
      if (s[0]) return;
    end
    chk({req, " over timeout"}, 0, 1);
  endtask

  task automatic cmd(input logic [4:0] c, input string req);
    wr(5'h04, {27'd0, c});
    wait_over(req);
    repeat (4) @(negedge clk);
  endtask

  logic [31:0] v;
  int seen;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(5'h0C, v); chk("R1 status", v, 0);
    rd(5'h00, v); chk("R1 control", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 lines", {scl_oe, sda_oe}, 0);

    wr(5'h10, HI); wr(5'h14, LO); wr(5'h00, 32'h181);

    wr(5'h18, 8'hA4); cmd(5'h0A, "R3");
    rd(5'h0C, v); chk("R3 status", v, 32'hD1);
    chk("R3 start seen", n_start, 1);
    chk("R3 byte", rxq[$], 8'hA4);
    chk("R9 irq over", irq, 1);
    wr(5'h08, 32'h7F);
    rd(5'h0C, v); chk("R8 clear all", v, 32'h80);
    chk("R9 irq cleared", irq, 0);

    wr(5'h18, 8'h37); cmd(5'h02, "R3");
    rd(5'h0C, v); chk("R3 write only", v, 32'h91);
    chk("R3 byte2", rxq[$], 8'h37);
    wr(5'h08, 32'h7F);

    ack_en = 0;
    wr(5'h18, 8'h11); cmd(5'h02, "R4");
    ack_en = 1;
    rd(5'h0C, v); chk("R4 ack error", v, 32'h95);
    wr(5'h08, 32'h0);
    rd(5'h0C, v); chk("R8 zero write", v, 32'h95);
    wr(5'h08, 32'h04);
    rd(5'h0C, v); chk("R8 single clear", v, 32'h91);
    wr(5'h08, 32'h7F);

    cmd(5'h01, "R7");
    rd(5'h0C, v); chk("R7 stop status", v, 32'h21);
    chk("R7 stop seen", n_stop, 1);
    wr(5'h08, 32'h7F);

    txq.push_back(8'h5C); txq.push_back(8'h96);
    wr(5'h18, 8'hA5); cmd(5'h0A, "R5");
    wr(5'h08, 32'h7F);
    cmd(5'h04, "R5");
    rd(5'h0C, v); chk("R5 status", v, 32'h89);
    rd(5'h1C, v); chk("R5 rx byte", v, 8'h5C);
    chk("R5 master ack", mack, 0);
    wr(5'h08, 32'h7F);
    cmd(5'h14, "R6");
    rd(5'h1C, v); chk("R6 rx byte", v, 8'h96);
    chk("R6 master nack", mack, 1);
    wr(5'h08, 32'h7F);
    cmd(5'h01, "R7");
    rd(5'h0C, v); chk("R7 busy cleared", v, 32'h21);
    wr(5'h08, 32'h7F);

    wr(5'h18, 8'hFF);
    wr(5'h04, 32'h02);
    @(negedge scl_line); force_low = 1;
    wait_over("R10");
    rd(5'h0C, v); chk("R10 arb flags", v[6:0], 7'h03);
    chk("R10 lines released", {scl_oe, sda_oe}, 0);
    repeat (4) @(negedge clk);
    force_low = 0;
    repeat (8) @(negedge clk);
    wr(5'h08, 32'h7F);

    wr(5'h18, 8'h3C);
    wr(5'h04, 32'h0A);
    repeat (3) @(negedge clk);
    wr(5'h04, 32'h04);
    wait_over("R11");
    rd(5'h0C, v); chk("R11 no read done", v, 32'hD1);
    chk("R11 byte", rxq[$], 8'h3C);
    seen = 0;
    repeat (200) begin @(negedge clk); if (scl_oe) seen++; end
    chk("R11 bus quiet", seen, 0);
    wr(5'h08, 32'h7F);
    cmd(5'h01, "R7");
    wr(5'h08, 32'h7F);

    seen = n_stop;
    wr(5'h18, 8'h42); cmd(5'h0B, "R12");
    rd(5'h0C, v); chk("R12 combined status", v, 32'h71);
    chk("R12 byte", rxq[$], 8'h42);
    chk("R12 stop seen", n_stop, seen + 1);

    wr(5'h00, 32'h1A0); chk("R9 stop unmasked", irq, 1);
    wr(5'h00, 32'h120); chk("R9 global off", irq, 0);
    wr(5'h00, 32'h188); chk("R9 other source", irq, 0);
    wr(5'h00, 32'h181); chk("R9 over unmasked", irq, 1);
    wr(5'h08, 32'h7F);  chk("R9 after clear", irq, 0);

    wr(5'h00, 32'h081);
    wr(5'h04, 32'h0A);
    seen = 0;
    repeat (100) begin @(negedge clk); if (scl_oe) seen++; end
    chk("R13 no bus activity", seen, 0);
    rd(5'h0C, v); chk("R13 status", v, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule